// File: doc/BRIEF.md
# Binary Template Correlator with Ones Counter

This block scores binary template matches one row at a time. A caller hands it an 8-bit template row together with a 16-bit word of packed binary image pixels. Over the next eight clock cycles the block masks the top byte of the image word with the template and counts the set bits of the masked result. Each count is a match score, between 0 and 8, for one horizontal candidate offset. After each count the image word moves one bit to the left. The eight scores therefore cover eight adjacent candidate offsets. On the final count the block asks for a new word.

A second path inside the block builds binary image bytes from grey-level pixels. For each pixel the caller presents a signed pixel value and a signed shape sum. The block forms one threshold bit from the sign of their difference. Eight of these bits, oldest first, are packed into a byte for write-back.

Scanner states: `ST_IDLE` (waiting for a word) and `ST_SCAN` (stepping through the eight candidates). The scanner has three transitions:
- `ST_IDLE` to `ST_SCAN` when a load is presented.
- `ST_SCAN` to `ST_IDLE` on the last step with no load present.
- `ST_SCAN` to `ST_SCAN` on the last step with a load present. This reloads the word with no idle gap.

Top module: `bin_match_core`

## Requirements
- R1: While reset is held, `busy_o`, `load_req_o`, `score_vld_o` and `pack_vld_o` are 0, and `score_o` is 0.
- R2: A load (`load_i`=1) seen at a clock edge while idle starts a group. `busy_o` is then 1 for exactly eight cycles.
- R3: Step k (k = 0 to 7) of a group scores the popcount of (template AND image bits [15-k : 8-k]). Bits shifted in from the right are 0. The score appears on `score_o` with `score_vld_o`=1 in the cycle after that step.
- R4: `load_req_o` is 1 only during the eighth step of a group. It is 0 at all other times.
- R5: A load presented during the eighth step is taken at once, and the next group starts in the following cycle. A load presented during steps 0 to 6 is ignored, and the current group's scores are unchanged.
- R6: The template is captured together with the image word. A change on `tmpl_i` during a group does not alter that group's scores.
- R7: For each pixel, the threshold bit is 1 when the signed 17-bit difference `pix_i - shape_sum_i` is greater than 0. It is 0 when the difference is zero or negative. Both inputs are 16-bit two's complement.
- R8: Threshold bits are packed MSB first: the first pixel of a group of eight lands in bit 7. In the cycle after the eighth pixel, `pack_byte_o` holds the byte and `pack_vld_o` pulses for one cycle. The packer then starts empty.
- R9: `score_o` is an unsigned binary count from 0 to 8. An all-ones template over all-ones image bits gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Present a new image word and template |
| img_word_i | input | 16 | Packed binary image pixels, leftmost pixel in bit 15 |
| tmpl_i | input | 8 | Template row |
| busy_o | output | 1 | A group of eight steps is in progress |
| load_req_o | output | 1 | Last step of the group; a load is taken now |
| score_o | output | 4 | Match count for one candidate offset |
| score_vld_o | output | 1 | `score_o` holds a fresh count |
| pix_vld_i | input | 1 | Pixel and shape sum are valid |
| pix_i | input | 16 | Signed pixel value |
| shape_sum_i | input | 16 | Signed shape sum |
| pack_byte_o | output | 8 | Packed threshold byte |
| pack_vld_o | output | 1 | One-cycle pulse when `pack_byte_o` is new |

## Verification
When a load is taken at edge E0, the busy flag rises after E0. The score for step k is due after edge E(k+1), and the load request is visible between E7 and E8. A packed byte is due one edge after the edge that takes the eighth pixel. The bench drives inputs and compares outputs at falling edges. Its reference model advances on every rising edge using only the inputs it applied. Each comparison therefore reads exactly the value that the latency above predicts for that cycle. Dedicated sequences cover the chained load, the ignored mid-group load, the mid-group template change, a zero difference and the extremes of the signed range.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/bmc_popcount.sv
module bmc_popcount #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);

    // Two-level sum: pairs are formed first, then their counts are accumulated.
    localparam int PAIRS = (W + 1) / 2;

    logic [1:0] pair_sum [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        if (2 * p + 1 < W) begin : g_full
            assign pair_sum[p] = {1'b0, bits_i[2*p]} + {1'b0, bits_i[2*p+1]};
        end else begin : g_odd
            assign pair_sum[p] = {1'b0, bits_i[2*p]};
        end
    end

    always_comb begin
        count_o = '0;
        for (int p = 0; p < PAIRS; p++) begin
            count_o = count_o + CW'(pair_sum[p]);
        end
    end

    always_comb begin
        a_r9_count_bound: assert (count_o <= CW'(W));
    end

endmodule

// File: rtl/bmc_scan_ctrl.sv
module bmc_scan_ctrl
    import bmc_pkg::*;
#(
    parameter int TMPL_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [TMPL_W-1:0] tmpl_i,
    output logic              busy_o,
    output logic              load_req_o,
    output logic [TMPL_W-1:0] win_o,
    output logic [TMPL_W-1:0] tmpl_o
);

    localparam int STEPS  = WORD_W - TMPL_W;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    scan_state_e       st_q, st_d;
    logic [WORD_W-1:0] img_q;
    logic [TMPL_W-1:0] tmpl_q;
    logic [STEP_W-1:0] step_q;
    logic              last_step;
    logic              take;

    assign last_step = (st_q == ST_SCAN) && (step_q == LAST);
    assign take      = load_i && ((st_q == ST_IDLE) || last_step);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (load_i) st_d = ST_SCAN;
            ST_SCAN: if (last_step && !load_i) st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // image shifter, captured template and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q  <= '0;
            tmpl_q <= '0;
            step_q <= '0;
        end else if (take) begin
            img_q  <= word_i;
            tmpl_q <= tmpl_i;
            step_q <= '0;
        end else if (st_q == ST_SCAN) begin
            img_q  <= {img_q[WORD_W-2:0], 1'b0};
            step_q <= step_q + STEP_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o     = (st_q == ST_SCAN);
        load_req_o = last_step;
        win_o      = img_q[WORD_W-1 -: TMPL_W];
        tmpl_o     = tmpl_q;
    end

    a_r4_req_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> busy_o);

    a_r2_group_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req_o && !load_i) |=> !busy_o);

    a_r5_chain_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req_o && load_i) |=> (busy_o && !load_req_o));

    a_r2_starts_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && load_i) |=> busy_o);

endmodule

// File: rtl/bmc_thr_pack.sv
module bmc_thr_pack #(
    parameter int PIX_W  = 16,
    parameter int PACK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [PIX_W-1:0]  sum_i,
    output logic [PACK_W-1:0] byte_o,
    output logic              byte_vld_o
);

    localparam int CNT_W = (PACK_W > 1) ? $clog2(PACK_W) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PACK_W - 1);

    logic signed [PIX_W:0] diff;
    logic                  thr_bit;
    logic [PACK_W-1:0]     sh_q;
    logic [CNT_W-1:0]      cnt_q;

    // sign-extended difference cannot overflow
    assign diff    = $signed({pix_i[PIX_W-1], pix_i}) - $signed({sum_i[PIX_W-1], sum_i});
    assign thr_bit = !diff[PIX_W] && (diff != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (pix_vld_i) begin
                if (cnt_q == FULL) begin
                    byte_o     <= {sh_q[PACK_W-2:0], thr_bit};
                    byte_vld_o <= 1'b1;
                    sh_q       <= '0;
                    cnt_q      <= '0;
                end else begin
                    sh_q  <= {sh_q[PACK_W-2:0], thr_bit};
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    a_r8_starts_empty: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> (sh_q == '0 && cnt_q == '0));

endmodule

// File: rtl/bin_match_core.sv
module bin_match_core #(
    parameter int TMPL_W = 8,
    parameter int WORD_W = 16,
    parameter int PIX_W  = 16,
    localparam int CNT_W = $clog2(TMPL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] img_word_i,
    input  logic [TMPL_W-1:0] tmpl_i,
    output logic              busy_o,
    output logic              load_req_o,
    output logic [CNT_W-1:0]  score_o,
    output logic              score_vld_o,
    input  logic              pix_vld_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [PIX_W-1:0]  shape_sum_i,
    output logic [TMPL_W-1:0] pack_byte_o,
    output logic              pack_vld_o
);

    logic [TMPL_W-1:0] win;
    logic [TMPL_W-1:0] tmpl_cap;
    logic [CNT_W-1:0]  count;

    bmc_scan_ctrl #(.TMPL_W(TMPL_W), .WORD_W(WORD_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .word_i     (img_word_i),
        .tmpl_i     (tmpl_i),
        .busy_o     (busy_o),
        .load_req_o (load_req_o),
        .win_o      (win),
        .tmpl_o     (tmpl_cap)
    );

    bmc_popcount #(.W(TMPL_W)) u_pop (
        .bits_i  (win & tmpl_cap),
        .count_o (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_o     <= '0;
            score_vld_o <= 1'b0;
        end else begin
            score_vld_o <= busy_o;
            if (busy_o) score_o <= count;
        end
    end

    bmc_thr_pack #(.PIX_W(PIX_W), .PACK_W(TMPL_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_vld_i  (pix_vld_i),
        .pix_i      (pix_i),
        .sum_i      (shape_sum_i),
        .byte_o     (pack_byte_o),
        .byte_vld_o (pack_vld_o)
    );

    a_r3_strobe_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> score_vld_o);

    a_r3_no_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !score_vld_o);

    a_r9_score_range: assert property (@(posedge clk) disable iff (!rst_n)
        score_vld_o |-> (score_o <= CNT_W'(TMPL_W)));

endmodule

// File: tb/bin_match_core_test.sv
module bin_match_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] img_word_i = '0;
    logic [7:0]  tmpl_i = '0;
    logic        busy_o, load_req_o, score_vld_o, pix_vld_i = 1'b0, pack_vld_o;
    logic [3:0]  score_o;
    logic [15:0] pix_i = '0, shape_sum_i = '0;
    logic [7:0]  pack_byte_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    string score_tag = "R3";
    string pack_tag = "R8";

    always #10 clk = ~clk;

    bin_match_core uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .img_word_i(img_word_i),
        .tmpl_i(tmpl_i), .busy_o(busy_o), .load_req_o(load_req_o),
        .score_o(score_o), .score_vld_o(score_vld_o), .pix_vld_i(pix_vld_i),
        .pix_i(pix_i), .shape_sum_i(shape_sum_i), .pack_byte_o(pack_byte_o),
        .pack_vld_o(pack_vld_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_busy = 0, m_step = 0, m_word = 0, m_tmpl = 0;
    int e_sv = 0, e_score = 0;
    int m_pack = 0, m_cnt = 0, e_pv = 0, e_byte = 0;

    function automatic int ones(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) if (v[i]) c++;
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_step = 0; m_word = 0; m_tmpl = 0;
            e_sv = 0; e_score = 0; m_pack = 0; m_cnt = 0; e_pv = 0; e_byte = 0;
        end else begin
            if (m_busy != 0) begin
                e_sv = 1;
                e_score = ones(m_tmpl & ((m_word >> 8) & 255));
            end else e_sv = 0;
            if (load_i && (m_busy == 0 || m_step == 7)) begin
                m_word = int'(img_word_i); m_tmpl = int'(tmpl_i); m_step = 0; m_busy = 1;
            end else if (m_busy != 0) begin
                m_word = (m_word << 1) & 16'hFFFF;
                if (m_step == 7) m_busy = 0;
                m_step = m_step + 1;
            end
            e_pv = 0;
            if (pix_vld_i) begin
                int d;
                d = int'($signed(pix_i)) - int'($signed(shape_sum_i));
                m_pack = ((m_pack << 1) | ((d > 0) ? 1 : 0)) & 255;
                m_cnt++;
                if (m_cnt == 8) begin
                    e_byte = m_pack; e_pv = 1; m_pack = 0; m_cnt = 0;
                end
            end
        end
    end

    int e_req;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_req = (m_busy != 0 && m_step == 7) ? 1 : 0;
            chk(busy_o == m_busy[0], "R2 busy", busy_o, m_busy);
            chk(load_req_o == e_req[0], "R4 load request", load_req_o, e_req);
            chk(score_vld_o == e_sv[0], "R3 score strobe", score_vld_o, e_sv);
            if (e_sv != 0) chk(int'(score_o) == e_score, score_tag, score_o, e_score);
            chk(pack_vld_o == e_pv[0], "R8 byte pulse", pack_vld_o, e_pv);
            if (e_pv != 0) chk(int'(pack_byte_o) == e_byte, pack_tag, pack_byte_o, e_byte);
        end
    end

    task automatic load(input logic [15:0] w, input logic [7:0] t);
        @(negedge clk);
        load_i = 1'b1; img_word_i = w; tmpl_i = t;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pixel(input int p, input int s);
        @(negedge clk);
        pix_vld_i = 1'b1; pix_i = 16'(p); shape_sum_i = 16'(s);
        @(negedge clk);
        pix_vld_i = 1'b0;
    endtask

    // watchdog
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(2);
        chk(busy_o == 0 && load_req_o == 0, "R1 busy/req in reset", {busy_o, load_req_o}, 0);
        chk(score_vld_o == 0 && score_o == 0, "R1 score in reset", score_o, 0);
        chk(pack_vld_o == 0, "R1 byte pulse in reset", pack_vld_o, 0);
        rst_n = 1'b1;
        idle(2);

        // R3 basic patterns
        score_tag = "R3 pattern A";
        load(16'hB5A3, 8'hF0);
        idle(10);
        score_tag = "R3 pattern B";
        load(16'h1234, 8'hA5);
        idle(10);

        // R5 load ignored mid-group, R6 template change ignored
        score_tag = "R5/R6 ignored load and template";
        load(16'hC3C3, 8'h3C);
        idle(2);
        load(16'hFFFF, 8'hFF);
        tmpl_i = 8'h00;
        idle(8);

        // R5 chained load on the last step
        score_tag = "R5 chained group";
        load(16'h0F0F, 8'hFF);
        while (!load_req_o) @(negedge clk);
        load_i = 1'b1; img_word_i = 16'hAAAA; tmpl_i = 8'h81;
        @(negedge clk);
        load_i = 1'b0;
        chk(busy_o == 1, "R5 no gap after chained load", busy_o, 1);
        idle(10);

        // R9 full count
        score_tag = "R9 all ones";
        load(16'hFFFF, 8'hFF);
        idle(2);
        chk(score_vld_o == 1 && score_o == 8, "R9 score of eight", score_o, 8);
        idle(9);
        score_tag = "R3 zero template";
        load(16'hFFFF, 8'h00);
        idle(10);

        // R7 threshold and R8 packing
        pack_tag = "R7/R8 byte contents";
        pixel(10, 3);        // +  -> bit7 = 1
        pixel(5, 5);         // 0  -> 0
        pixel(-4, 2);        // -  -> 0
        pixel(32767, -32768);// large + -> 1
        pixel(-32768, 32767);// large - -> 0
        pixel(1, 0);         // +  -> 1
        pixel(0, 1);         // -  -> 0
        pixel(-1, -2);       // +  -> 1
        @(negedge clk);
        chk(pack_byte_o == 8'b1001_0101, "R7 zero diff gives 0, MSB first", pack_byte_o, 8'h95);
        idle(1);
        chk(pack_vld_o == 0, "R8 single pulse", pack_vld_o, 0);
        pack_tag = "R8 cleared packer";
        for (int i = 0; i < 8; i++) pixel(0, 0);
        idle(2);
        pack_tag = "R8 back to back";
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pix_vld_i = 1'b1; pix_i = 16'(i * 37 - 200); shape_sum_i = 16'(i * 11 - 50);
        end
        @(negedge clk);
        pix_vld_i = 1'b0;
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule